// File: doc/BRIEF.md
# USB Port Suspend and Wake Controller

This block governs the low-power state of a USB port that can act as host or as device. Software puts the port to sleep by pulsing a suspend-set strobe. The block then drives the transceiver suspend line. One cycle later it raises a flag saying the high-speed PLL may be stopped. It also drops its request for the bus clock, so the system can gate or slow that clock.

The block leaves low power when software pulses a suspend-clear strobe, or when a hardware wake source fires. Which hardware sources count depends on the mode. In host mode they are:
- a connect edge, a disconnect edge or an over-current edge, each only while its own enable is set;
- a remote-wake edge while the bus is suspended;
- any change on either VBUS comparator.

In device mode, only a change on the data-line state counts. All asynchronous inputs pass through a two-stage synchroniser before edge detection. A hardware wake sets a sticky interrupt flag. An enable masks that flag onto the interrupt output, and software clears it by writing one.

The control path is a three-state machine:
- `ST_AWAKE`: full power. It goes to `ST_SUSP_ENTRY` on a set strobe with no wake present.
- `ST_SUSP_ENTRY`: transceiver suspended, PLL still required. It returns to `ST_AWAKE` on a wake, and otherwise moves to `ST_PLL_OFF` on the next cycle.
- `ST_PLL_OFF`: transceiver suspended and PLL may stop. It returns to `ST_AWAKE` on a wake.

Top module: `usb_susp_wake`

## Requirements
- R1: After reset the block is in `ST_AWAKE`: `phy_susp`=0, `pll_off_ok`=0, `clk_req`=1, `wake_irq`=0. A `sw_set_susp` pulse with no wake present makes `phy_susp`=1 from the next clock edge. Nothing else raises `phy_susp`.
- R2: `pll_off_ok` rises exactly one cycle after `phy_susp` rises, and is only ever high while `phy_susp` is high. On a wake, both fall at the same clock edge.
- R3: `clk_req` is 1 exactly when `phy_susp` is 0.
- R4: In either mode, a `sw_clr_susp` pulse while suspended clears `phy_susp` at the next edge, without setting the interrupt flag.
- R5: In host mode (`host_mode`=1), a rising edge on `conn_det`, `disc_det` or `ovc_det` wakes the block only if `wk_en_conn`, `wk_en_disc` or `wk_en_oc` respectively is 1. With the enable at 0 the block stays suspended.
- R6: In host mode, a rising edge on `rmt_wake` wakes the block only while `bus_suspended`=1. Any change, in either direction, on `vbus_valid` or `b_valid` always wakes it.
- R7: In device mode (`host_mode`=0), any change on `line_state` wakes the block. Every host-only source is ignored.
- R8: In host mode, a change on `line_state` does not wake the block.
- R9: An asynchronous input change is taken through two synchroniser flops plus an edge register. `phy_susp` falls at the third rising clock edge after the change, and not at the second.
- R10: A hardware wake from a suspended state sets a sticky flag. `wake_irq` equals that flag ANDed with `irq_en`, and the flag is kept while masked. Writing `irq_clr`=1 clears it. If a set and a clear occur in the same cycle, the set wins.
- R11: If a hardware wake is detected in the same cycle as `sw_set_susp`, or if `sw_set_susp` and `sw_clr_susp` arrive together, the block stays in `ST_AWAKE` and the flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_set_susp | input | 1 | Software strobe: enter low power |
| sw_clr_susp | input | 1 | Software strobe: leave low power |
| host_mode | input | 1 | 1 = host, 0 = device |
| wk_en_conn | input | 1 | Host wake-on-connect enable |
| wk_en_disc | input | 1 | Host wake-on-disconnect enable |
| wk_en_oc | input | 1 | Host wake-on-over-current enable |
| bus_suspended | input | 1 | Bus is in suspend (qualifies remote wake) |
| conn_det | input | 1 | Async connect indication |
| disc_det | input | 1 | Async disconnect indication |
| ovc_det | input | 1 | Async over-current indication |
| rmt_wake | input | 1 | Async remote-wake indication from the attached device |
| vbus_valid | input | 1 | Async VBUS high-threshold comparator |
| b_valid | input | 1 | Async VBUS session comparator |
| line_state | input | 2 | Async data-line state |
| irq_en | input | 1 | Wake interrupt enable mask |
| irq_clr | input | 1 | Write-one-to-clear for the wake flag |
| phy_susp | output | 1 | Transceiver suspend line |
| pll_off_ok | output | 1 | PLL may be stopped |
| clk_req | output | 1 | Bus clock still required |
| wake_irq | output | 1 | Masked wake interrupt |

## Verification
Two functions can fall in the same cycle: a suspend request and a hardware wake detection. The bench provokes this by toggling a VBUS comparator in host mode. It then times `sw_set_susp` to land on the cycle in which the synchronised edge is seen, which is two edges after the toggle. It judges the outcome by requiring `phy_susp` to stay low and `wake_irq` to stay low. A second collision, set and clear strobes together, is judged the same way. Random rounds then mix the mode, the source, the enables and the bus-suspended flag. Each outcome is compared against a bench function that encodes the wake rules.

// File: rtl/usb_sw_pkg.sv
package usb_sw_pkg;

    typedef enum logic [1:0] {
        ST_AWAKE      = 2'd0,
        ST_SUSP_ENTRY = 2'd1,
        ST_PLL_OFF    = 2'd2
    } pwr_state_t;

    // bit positions inside the synchronised input vector
    localparam int IDX_CONN  = 0;
    localparam int IDX_DISC  = 1;
    localparam int IDX_OVC   = 2;
    localparam int IDX_RWAKE = 3;
    localparam int IDX_VBUS  = 4;
    localparam int IDX_BVAL  = 5;
    localparam int IDX_LS0   = 6;
    localparam int IDX_LS1   = 7;
    localparam int N_ASYNC   = 8;

endpackage

// File: rtl/usb_sw_sync.sv
module usb_sw_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] cur_q,
    output logic [WIDTH-1:0] prev_q
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stg[LAST];
    end

    assign cur_q = stg[LAST];

endmodule

// File: rtl/usb_sw_wake_src.sv
module usb_sw_wake_src
    import usb_sw_pkg::*;
(
    input  logic               host_mode,
    input  logic               wk_en_conn,
    input  logic               wk_en_disc,
    input  logic               wk_en_oc,
    input  logic               bus_suspended,
    input  logic [N_ASYNC-1:0] cur_q,
    input  logic [N_ASYNC-1:0] prev_q,
    output logic               wake_hw
);
    logic [N_ASYNC-1:0] rise;
    logic [N_ASYNC-1:0] chg;
    logic               host_wake;
    logic               dev_wake;

    always_comb begin
        rise = cur_q & ~prev_q;
        chg  = cur_q ^ prev_q;
        host_wake = (rise[IDX_CONN]  & wk_en_conn)
                  | (rise[IDX_DISC]  & wk_en_disc)
                  | (rise[IDX_OVC]   & wk_en_oc)
                  | (rise[IDX_RWAKE] & bus_suspended)
                  | chg[IDX_VBUS]
                  | chg[IDX_BVAL];
        dev_wake  = chg[IDX_LS0] | chg[IDX_LS1];
        wake_hw   = host_mode ? host_wake : dev_wake;
    end

endmodule

// File: rtl/usb_sw_fsm.sv
module usb_sw_fsm
    import usb_sw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic wake_hw,
    output logic phy_susp,
    output logic pll_off_ok,
    output logic clk_req,
    output logic hw_wake_taken
);
    pwr_state_t state_q, state_d;
    logic       wake_any;

    assign wake_any = wake_hw | sw_clr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AWAKE:      if (sw_set && !wake_any) state_d = ST_SUSP_ENTRY;
            ST_SUSP_ENTRY: state_d = wake_any ? ST_AWAKE : ST_PLL_OFF;
            ST_PLL_OFF:    if (wake_any) state_d = ST_AWAKE;
            default:       state_d = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_AWAKE;
        else        state_q <= state_d;
    end

    always_comb begin
        phy_susp      = 1'b0;
        pll_off_ok    = 1'b0;
        clk_req       = 1'b1;
        hw_wake_taken = 1'b0;
        unique case (state_q)
            ST_AWAKE: begin
                clk_req = 1'b1;
            end
            ST_SUSP_ENTRY: begin
                phy_susp      = 1'b1;
                clk_req       = 1'b0;
                hw_wake_taken = wake_hw;
            end
            ST_PLL_OFF: begin
                phy_susp      = 1'b1;
                pll_off_ok    = 1'b1;
                clk_req       = 1'b0;
                hw_wake_taken = wake_hw;
            end
            default: begin
                clk_req = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/usb_susp_wake.sv
module usb_susp_wake
    import usb_sw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_set_susp,
    input  logic       sw_clr_susp,
    input  logic       host_mode,
    input  logic       wk_en_conn,
    input  logic       wk_en_disc,
    input  logic       wk_en_oc,
    input  logic       bus_suspended,
    input  logic       conn_det,
    input  logic       disc_det,
    input  logic       ovc_det,
    input  logic       rmt_wake,
    input  logic       vbus_valid,
    input  logic       b_valid,
    input  logic [1:0] line_state,
    input  logic       irq_en,
    input  logic       irq_clr,
    output logic       phy_susp,
    output logic       pll_off_ok,
    output logic       clk_req,
    output logic       wake_irq
);
    logic [N_ASYNC-1:0] raw_in;
    logic [N_ASYNC-1:0] cur_q;
    logic [N_ASYNC-1:0] prev_q;
    logic               wake_hw;
    logic               hw_wake_taken;
    logic               irq_pend;

    always_comb begin
        raw_in            = '0;
        raw_in[IDX_CONN]  = conn_det;
        raw_in[IDX_DISC]  = disc_det;
        raw_in[IDX_OVC]   = ovc_det;
        raw_in[IDX_RWAKE] = rmt_wake;
        raw_in[IDX_VBUS]  = vbus_valid;
        raw_in[IDX_BVAL]  = b_valid;
        raw_in[IDX_LS0]   = line_state[0];
        raw_in[IDX_LS1]   = line_state[1];
    end

    usb_sw_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .cur_q    (cur_q),
        .prev_q   (prev_q)
    );

    usb_sw_wake_src u_src (
        .host_mode     (host_mode),
        .wk_en_conn    (wk_en_conn),
        .wk_en_disc    (wk_en_disc),
        .wk_en_oc      (wk_en_oc),
        .bus_suspended (bus_suspended),
        .cur_q         (cur_q),
        .prev_q        (prev_q),
        .wake_hw       (wake_hw)
    );

    usb_sw_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_set        (sw_set_susp),
        .sw_clr        (sw_clr_susp),
        .wake_hw       (wake_hw),
        .phy_susp      (phy_susp),
        .pll_off_ok    (pll_off_ok),
        .clk_req       (clk_req),
        .hw_wake_taken (hw_wake_taken)
    );

    // sticky wake flag, a new wake beats a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             irq_pend <= 1'b0;
        else if (hw_wake_taken) irq_pend <= 1'b1;
        else if (irq_clr)       irq_pend <= 1'b0;
    end

    assign wake_irq = irq_pend & irq_en;

endmodule

// File: rtl/usb_susp_wake_chk.sv
module usb_susp_wake_chk (
    input logic clk,
    input logic rst_n,
    input logic sw_set_susp,
    input logic sw_clr_susp,
    input logic irq_clr,
    input logic phy_susp,
    input logic pll_off_ok,
    input logic wake_hw,
    input logic irq_pend
);
    AST_SUSP_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_susp) |-> $past(sw_set_susp)); // R1
    AST_PLL_FOLLOWS_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_off_ok) |-> $past(phy_susp)); // R2
    AST_PLL_INSIDE_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        pll_off_ok |-> phy_susp); // R2
    AST_CLR_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_susp && sw_clr_susp) |=> !phy_susp); // R4
    AST_HW_WAKE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_susp && wake_hw) |=> (irq_pend && !phy_susp)); // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend && !irq_clr) |=> irq_pend); // R10
    AST_WAKE_BEATS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!phy_susp && sw_set_susp && (wake_hw || sw_clr_susp)) |=> !phy_susp); // R11
endmodule

bind usb_susp_wake usb_susp_wake_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_set_susp (sw_set_susp),
    .sw_clr_susp (sw_clr_susp),
    .irq_clr     (irq_clr),
    .phy_susp    (phy_susp),
    .pll_off_ok  (pll_off_ok),
    .wake_hw     (wake_hw),
    .irq_pend    (irq_pend)
);

// File: tb/usb_susp_wake_bench.sv
module usb_susp_wake_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_set_susp = 1'b0, sw_clr_susp = 1'b0, host_mode = 1'b1;
    logic       wk_en_conn = 1'b0, wk_en_disc = 1'b0, wk_en_oc = 1'b0;
    logic       bus_suspended = 1'b0;
    logic       conn_det = 1'b0, disc_det = 1'b0, ovc_det = 1'b0, rmt_wake = 1'b0;
    logic       vbus_valid = 1'b0, b_valid = 1'b0;
    logic [1:0] line_state = 2'b00;
    logic       irq_en = 1'b1, irq_clr = 1'b0;
    logic       phy_susp, pll_off_ok, clk_req, wake_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    usb_susp_wake u_usb_susp_wake (
        .clk(clk), .rst_n(rst_n), .sw_set_susp(sw_set_susp), .sw_clr_susp(sw_clr_susp),
        .host_mode(host_mode), .wk_en_conn(wk_en_conn), .wk_en_disc(wk_en_disc),
        .wk_en_oc(wk_en_oc), .bus_suspended(bus_suspended), .conn_det(conn_det),
        .disc_det(disc_det), .ovc_det(ovc_det), .rmt_wake(rmt_wake),
        .vbus_valid(vbus_valid), .b_valid(b_valid), .line_state(line_state),
        .irq_en(irq_en), .irq_clr(irq_clr), .phy_susp(phy_susp),
        .pll_off_ok(pll_off_ok), .clk_req(clk_req), .wake_irq(wake_irq)
    );

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(logic got, logic exp, string req, string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    // source codes: 0 conn, 1 disc, 2 ovc, 3 remote wake, 4 vbus, 5 bvalid, 6 line
    function automatic bit exp_wake(bit host, int src, bit en, bit bs);
        if (!host) return (src == 6);
        case (src)
            0, 1, 2: return en;
            3:       return bs;
            4, 5:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic drive_src(int src);
        case (src)
            0: conn_det   = 1'b1;
            1: disc_det   = 1'b1;
            2: ovc_det    = 1'b1;
            3: rmt_wake   = 1'b1;
            4: vbus_valid = ~vbus_valid;
            5: b_valid    = ~b_valid;
            default: line_state[0] = ~line_state[0];
        endcase
    endtask

    task automatic go_suspend();
        sw_set_susp = 1'b1;
        tick();
        sw_set_susp = 1'b0;
    endtask

    task automatic pulse_clr_irq();
        irq_clr = 1'b1;
        tick();
        irq_clr = 1'b0;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2024);

        // reset state (R1, R3)
        tick(3);
        rst_n = 1'b1;
        tick(4);
        chk(phy_susp, 1'b0, "R1", "reset phy_susp");
        chk(pll_off_ok, 1'b0, "R1", "reset pll_off_ok");
        chk(clk_req, 1'b1, "R3", "reset clk_req");
        chk(wake_irq, 1'b0, "R1", "reset wake_irq");

        // R1/R2/R3 entry sequence
        go_suspend();
        chk(phy_susp, 1'b1, "R1", "suspend after set");
        chk(pll_off_ok, 1'b0, "R2", "pll flag not yet");
        chk(clk_req, 1'b0, "R3", "clk_req in suspend");
        tick();
        chk(pll_off_ok, 1'b1, "R2", "pll flag one cycle later");

        // R4 software clear, no interrupt
        sw_clr_susp = 1'b1;
        tick();
        sw_clr_susp = 1'b0;
        chk(phy_susp, 1'b0, "R4", "sw clear wakes");
        chk(pll_off_ok, 1'b0, "R2", "pll flag cleared with suspend");
        chk(wake_irq, 1'b0, "R4", "no irq on sw clear");

        // R9 latency with vbus toggle in host mode
        host_mode = 1'b1;
        go_suspend();
        tick();
        vbus_valid = ~vbus_valid;
        tick(2);
        chk(phy_susp, 1'b1, "R9", "still suspended after two edges");
        tick();
        chk(phy_susp, 1'b0, "R9", "awake at third edge");
        chk(pll_off_ok, 1'b0, "R2", "pll flag falls with suspend");
        chk(wake_irq, 1'b1, "R10", "irq after hw wake");

        // R10 masking keeps the flag, clear removes it
        irq_en = 1'b0;
        tick();
        chk(wake_irq, 1'b0, "R10", "masked irq");
        irq_en = 1'b1;
        tick();
        chk(wake_irq, 1'b1, "R10", "flag kept while masked");
        pulse_clr_irq();
        chk(wake_irq, 1'b0, "R10", "write-one clear");

        // R11 wake detected in the same cycle as set
        b_valid = ~b_valid;
        tick(2);
        sw_set_susp = 1'b1;
        tick();
        sw_set_susp = 1'b0;
        chk(phy_susp, 1'b0, "R11", "wake beats set");
        chk(wake_irq, 1'b0, "R11", "no irq on collision");

        // R11 set and clear together
        sw_set_susp = 1'b1;
        sw_clr_susp = 1'b1;
        tick();
        sw_set_susp = 1'b0;
        sw_clr_susp = 1'b0;
        chk(phy_susp, 1'b0, "R11", "set+clear stays awake");

        // random rounds covering R5 R6 R7 R8
        for (int it = 0; it < 80; it++) begin
            int  src;
            bit  en, bs, exp;
            host_mode     = 1'($urandom);
            src           = int'($urandom_range(6, 0));
            en            = 1'($urandom);
            bs            = 1'($urandom);
            wk_en_conn    = en;
            wk_en_disc    = en;
            wk_en_oc      = en;
            bus_suspended = bs;
            tick();
            go_suspend();
            tick();
            chk(pll_off_ok, 1'b1, "R2", "random entry");
            drive_src(src);
            tick(3);
            exp = exp_wake(host_mode, src, en, bs);
            if (!host_mode)      chk(!phy_susp, exp, "R7", "device wake rule");
            else if (src == 6)   chk(!phy_susp, exp, "R8", "host ignores line");
            else if (src >= 3)   chk(!phy_susp, exp, "R6", "host rwake/vbus rule");
            else                 chk(!phy_susp, exp, "R5", "host enabled edge rule");
            chk(wake_irq, exp, "R10", "irq follows hw wake");
            if (exp) pulse_clr_irq();
            else begin
                sw_clr_susp = 1'b1;
                tick();
                sw_clr_susp = 1'b0;
            end
            conn_det = 1'b0;
            disc_det = 1'b0;
            ovc_det  = 1'b0;
            rmt_wake = 1'b0;
            tick(4);
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule